// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block is a bit-serial remainder engine for modulo-2 polynomial division. One shift register, sized by a width parameter and tapped by a polynomial parameter, serves both ends of a link. On the sending side it takes a message one bit per qualified cycle, feeds itself as many zero bits as the generator degree, and presents the remainder as the check sequence to append. On the receiving side it takes the complete frame, message and check bits together, and flags the frame as clean when the final remainder is zero.

A frame begins with a start strobe that clears the register and latches the mode. Bits follow most significant first, each qualified by a valid strobe, and the last one carries an end marker. Cycles with the valid strobe low are gaps and leave the register alone. The result then stays on the outputs until the next start strobe.

The control is a four-state machine. IDLE is the state after reset. COLLECT takes message or frame bits. FLUSH shifts in the implied zeros (generate mode only). DONE holds the result. Transitions: any state goes to COLLECT on start; COLLECT goes to FLUSH on the end-marked bit in generate mode, or to DONE on the end-marked bit in check mode; FLUSH goes to DONE after its last zero shift; IDLE and DONE otherwise hold.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset, and in the cycle after any start strobe, `rem_o` is all zeros and `rem_valid_o` and `pass_o` are low. `busy_o` is low after reset and high after a start strobe. A bit presented in the start cycle is not shifted in.
- R2: While collecting, each cycle with `bit_valid_i` high shifts one bit in, first bit = most significant term of the dividend. The remainder equals long division by the generator x^WIDTH + POLY (XOR arithmetic, no carries).
- R3: With `mode_i`=0 (generate, latched at start), the unit appends WIDTH zero bits internally. `rem_valid_o` rises exactly WIDTH cycles after the clock edge that takes the end-marked bit.
- R4: In generate mode the final `rem_o` is the check sequence. For generator 1011 and message 1101 it is 001. For generator 10101 and message 00111011001 it is 1101.
- R5: With `mode_i`=1 (check), no zeros are appended. `rem_valid_o` rises in the cycle right after the end-marked bit. `pass_o` is high exactly when the remainder is zero, so frame 1101001 passes with generator 1011 and a corrupted frame fails.
- R6: `pass_o` is low in generate mode and whenever `rem_valid_o` is low.
- R7: Once `rem_valid_o` is high, `rem_o`, `rem_valid_o` and `pass_o` hold until the next start strobe. Valid bits offered in DONE, FLUSH or IDLE are ignored.
- R8: A cycle with `bit_valid_i` low during collection leaves the remainder unchanged, so gaps between bits do not alter the result.
- R9: POLY holds the generator's low WIDTH coefficients, with x^WIDTH implied, and its bit 0 must be 1. Widths 3, 4, 16 and 32 are supported, including the standard 16-bit and 32-bit generators.
- R10: A start strobe in the middle of a frame abandons that frame and begins a new one from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame: clear register, latch mode |
| mode_i | input | 1 | 0 = generate, 1 = check; sampled with start_i |
| bit_valid_i | input | 1 | Qualifies bit_i and last_i |
| bit_i | input | 1 | Serial data bit, most significant first |
| last_i | input | 1 | Marks the final bit of the message or frame |
| rem_o | output | WIDTH | Current remainder / check sequence |
| rem_valid_o | output | 1 | Result is final and held |
| pass_o | output | 1 | Check mode: final remainder is zero |
| busy_o | output | 1 | Collecting or flushing |

## Verification
The bench builds five copies side by side, all driven by one shared bit stream: widths 3 and 4 with the small textbook generators, two 16-bit generators, and one 32-bit generator. The narrow copies make the worked division examples exact directed checks. The wide ones give the random frames a long feedback path to exercise, and they check the width-dependent flush latency over a range of 3 to 32 cycles. Because the copies differ only in parameters, every random frame tests the latency and remainder for each generator at once, while the reference division in the bench is the same for all of them.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FLUSH   = 2'd2,
        ST_DONE    = 2'd3
    } crc_state_e;

    typedef enum logic {
        MODE_GEN   = 1'b0,
        MODE_CHECK = 1'b1
    } crc_mode_e;

endpackage

// File: rtl/crc_ser_lfsr.sv
module crc_ser_lfsr #(
    parameter int                WIDTH = 16,
    parameter logic [WIDTH-1:0]  POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             din_i,
    output logic [WIDTH-1:0] rem_o
);

    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] rem_nxt;
    logic             feedback;

    assign feedback = rem_q[WIDTH-1];

    // One division step: shift the dividend bit in, subtract the
    // generator whenever the departing top term is set.
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_tap
            if (b == 0) begin : g_low
                assign rem_nxt[b] = din_i ^ (POLY[b] & feedback);
            end else begin : g_up
                assign rem_nxt[b] = rem_q[b-1] ^ (POLY[b] & feedback);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (clr_i) begin
            rem_q <= '0;
        end else if (shift_i) begin
            rem_q <= rem_nxt;
        end
    end

    assign rem_o = rem_q;

    // R8: register moves only when told to
    a_r8_hold_without_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !shift_i) |=> $stable(rem_q));

    // R1: clear wins
    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (rem_q == '0));

endmodule

// File: rtl/crc_ser_ctrl.sv
module crc_ser_ctrl
    import crc_ser_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mode_i,
    input  logic valid_i,
    input  logic bit_i,
    input  logic last_i,
    output logic clr_o,
    output logic shift_o,
    output logic din_o,
    output logic done_o,
    output logic busy_o,
    output logic check_o
);

    localparam int             CNT_W    = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    crc_state_e       state_q, state_d;
    crc_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = ST_IDLE;
            ST_COLLECT: begin
                if (valid_i && last_i) begin
                    state_d = (mode_q == MODE_CHECK) ? ST_DONE : ST_FLUSH;
                end
            end
            ST_FLUSH:   if (cnt_q == LAST_CNT) state_d = ST_DONE;
            ST_DONE:    state_d = ST_DONE;
            default:    state_d = ST_IDLE;
        endcase
        if (start_i) begin
            state_d = ST_COLLECT;
        end
    end

    // state register, mode latch and flush counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_GEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                mode_q <= crc_mode_e'(mode_i);
            end
            if (state_q == ST_FLUSH && !start_i) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        clr_o   = start_i;
        shift_o = 1'b0;
        din_o   = 1'b0;
        done_o  = 1'b0;
        busy_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_COLLECT: begin
                busy_o  = 1'b1;
                shift_o = valid_i && !start_i;
                din_o   = bit_i;
            end
            ST_FLUSH: begin
                busy_o  = 1'b1;
                shift_o = !start_i;
                din_o   = 1'b0;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign check_o = (mode_q == MODE_CHECK);

    // R3: flush count never passes the generator degree
    a_r3_flush_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (cnt_q < CNT_W'(WIDTH)));

    // R3: generate-mode results always come out of the flush
    a_r3_gen_done_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_o) && mode_q == MODE_GEN) |-> ($past(state_q) == ST_FLUSH));

    // R5: check mode never flushes
    a_r5_check_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |-> (mode_q == MODE_GEN));

    // R8: gaps keep the machine collecting
    a_r8_gap_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && !valid_i && !start_i) |=> (state_q == ST_COLLECT));

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
    parameter int                WIDTH = 16,
    parameter logic [WIDTH-1:0]  POLY  = 16'h1021
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic             last_i,
    output logic [WIDTH-1:0] rem_o,
    output logic             rem_valid_o,
    output logic             pass_o,
    output logic             busy_o
);

    logic clr, shift, din, done, check;

    crc_ser_ctrl #(.WIDTH(WIDTH)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .valid_i (bit_valid_i),
        .bit_i   (bit_i),
        .last_i  (last_i),
        .clr_o   (clr),
        .shift_o (shift),
        .din_o   (din),
        .done_o  (done),
        .busy_o  (busy_o),
        .check_o (check)
    );

    crc_ser_lfsr #(.WIDTH(WIDTH), .POLY(POLY)) i_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .shift_i (shift),
        .din_i   (din),
        .rem_o   (rem_o)
    );

    assign rem_valid_o = done;
    assign pass_o      = done && check && (rem_o == '0);

    // R1: start gives a clean, busy, not-yet-valid unit
    a_r1_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (rem_o == '0 && busy_o && !rem_valid_o));

    // R7: held result
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_valid_o && !start_i) |=> (rem_valid_o && $stable(rem_o) && $stable(pass_o)));

    // R7: idle unit ignores bit traffic
    a_r7_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(rem_o));

    // R6: no pass while busy
    a_r6_no_pass_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !pass_o);

endmodule

// File: tb/test_crc_serial_unit.sv
module test_crc_serial_unit;

    localparam int NI = 5;
    localparam int          NW [NI] = '{16, 3, 4, 16, 32};
    localparam logic [31:0] PL [NI] = '{32'h0000_8005, 32'h0000_0003, 32'h0000_0005,
                                        32'h0000_1021, 32'h04C1_1DB7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, mode_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, last_i = 1'b0;

    logic [31:0] rem_all  [NI];
    logic        rv_all   [NI];
    logic        pass_all [NI];
    logic        busy_all [NI];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    generate
        for (genvar g = 0; g < NI; g++) begin : g_inst
            logic [NW[g]-1:0] r;
            crc_serial_unit #(.WIDTH(NW[g]), .POLY(PL[g][NW[g]-1:0])) i_crc_serial_unit (
                .clk         (clk),
                .rst_n       (rst_n),
                .start_i     (start_i),
                .mode_i      (mode_i),
                .bit_valid_i (bit_valid_i),
                .bit_i       (bit_i),
                .last_i      (last_i),
                .rem_o       (r),
                .rem_valid_o (rv_all[g]),
                .pass_o      (pass_all[g]),
                .busy_o      (busy_all[g])
            );
            assign rem_all[g] = 32'(r);
        end
    endgenerate

    function automatic logic [31:0] ref_rem(input logic [31:0] poly, input int w,
                                            input logic [63:0] fr, input int k, input bit chk);
        logic [31:0] r = '0;
        logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        int total = chk ? k : k + w;
        for (int n = 0; n < total; n++) begin
            logic b = (n < k) ? fr[k-1-n] : 1'b0;
            logic fb = r[w-1];
            r = ((r << 1) | 32'(b)) & mask;
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Runs one frame on all instances; returns remainders seen.
    task automatic run_frame(input logic [63:0] fr, input int k, input bit chk,
                             input int gap_pct, output logic [31:0] got [NI]);
        logic [31:0] exp [NI];
        for (int g = 0; g < NI; g++) exp[g] = ref_rem(PL[g], NW[g], fr, k, chk);
        @(negedge clk);
        start_i = 1'b1; mode_i = chk; bit_valid_i = 1'b1; bit_i = 1'b1; last_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int g = 0; g < NI; g++) begin
            check("R1 rem cleared on start", rem_all[g], 32'd0);
            check("R1 busy after start", {31'd0, busy_all[g]}, 32'd1);
        end
        for (int i = k - 1; i >= 0; i--) begin
            while ($urandom_range(99) < gap_pct) begin
                bit_valid_i = 1'b0; bit_i = 1'($urandom); last_i = 1'($urandom);
                @(negedge clk);
            end
            bit_valid_i = 1'b1; bit_i = fr[i]; last_i = (i == 0);
            @(negedge clk);
        end
        // R7: traffic after the end marker must be ignored
        for (int c = 0; c <= 34; c++) begin
            for (int g = 0; g < NI; g++) begin
                int lat = chk ? 0 : NW[g];
                check(chk ? "R5 rem_valid timing" : "R3 rem_valid timing",
                      {31'd0, rv_all[g]}, {31'd0, c >= lat});
                if (c >= lat) begin
                    check("R7 result held", rem_all[g], exp[g]);
                    check("R6 pass flag", {31'd0, pass_all[g]},
                          {31'd0, chk && exp[g] == 32'd0});
                end else begin
                    check("R6 no pass before valid", {31'd0, pass_all[g]}, 32'd0);
                end
            end
            bit_valid_i = 1'($urandom); bit_i = 1'($urandom); last_i = 1'($urandom);
            @(negedge clk);
        end
        bit_valid_i = 1'b0; last_i = 1'b0;
        for (int g = 0; g < NI; g++) begin
            check("R2 remainder", rem_all[g], exp[g]);
            got[g] = rem_all[g];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] got [NI];
        logic [63:0] msg;
        int k;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            check("R1 reset rem", rem_all[g], 32'd0);
            check("R1 reset valid", {31'd0, rv_all[g]}, 32'd0);
            check("R1 reset busy", {31'd0, busy_all[g]}, 32'd0);
        end
        rst_n = 1'b1;
        // idle traffic ignored before any start (R7)
        repeat (4) begin
            @(negedge clk);
            bit_valid_i = 1'b1; bit_i = 1'b1;
        end
        @(negedge clk);
        bit_valid_i = 1'b0;
        check("R7 idle ignores bits", rem_all[0], 32'd0);

        // R4 directed: 1101 over 1011 -> 001
        run_frame(64'b1101, 4, 1'b0, 0, got);
        check("R4 gen 1101/1011", got[1], 32'b001);
        // R5 directed: 1101001 passes
        run_frame(64'b1101001, 7, 1'b1, 30, got);
        check("R5 check 1101001 pass", got[1], 32'd0);
        check("R5 pass flag", {31'd0, pass_all[1]}, 32'd1);
        // R5 corrupted
        run_frame(64'b1111001, 7, 1'b1, 0, got);
        check("R5 corrupted fails", {31'd0, pass_all[1]}, 32'd0);
        // R4 directed: 00111011001 over 10101 -> 1101
        run_frame(64'b00111011001, 11, 1'b0, 20, got);
        check("R4 gen over 10101", got[2], 32'b1101);

        // R10: abandoned frame
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) begin
            bit_valid_i = 1'b1; bit_i = 1'($urandom);
            @(negedge clk);
        end
        bit_valid_i = 1'b0;
        run_frame(64'b1101, 4, 1'b0, 0, got);
        check("R10 restart from zero", got[1], 32'b001);

        // Random frames: generate then check on the 16-bit main copy (R9)
        for (int t = 0; t < 25; t++) begin
            logic [63:0] frame;
            k = $urandom_range(48, 1);
            msg = {$urandom, $urandom} & ((64'd1 << k) - 64'd1);
            run_frame(msg, k, 1'b0, 25, got);
            frame = (msg << 16) | 64'(got[0][15:0]);
            if (t % 4 == 3) frame[$urandom_range(k + 15, 0)] ^= 1'b1;
            run_frame(frame, k + 16, 1'b1, 25, got);
            check("R9 16-bit frame verdict", {31'd0, pass_all[0]},
                  {31'd0, (t % 4) != 3});
        end
        summary();
    end

endmodule